// File: doc/BRIEF.md
# Alternate-Mode Lane Mux Controller

This block is the pin-strapped control logic of a USB Type-C alternate-mode lane switch. It watches two mode pins, an orientation pin, a hot-plug input, a snoop-disable pin and a snooped link-width code. From these it drives registered enables for the USB path, for DisplayPort lane pair 0 (lanes 0-1) and pair 1 (lanes 2-3). It also drives a lane-swap select, the four closures of the AUX-to-SBU switch and a shutdown flag.

All inputs pass through a two-flop synchronizer. The second mode pin and the hot-plug input take effect at once when they rise. When they fall, the change only takes effect after `DEB_TICKS` pulses of a 1 kHz tick enable while the input stays low. A rise in that window restarts the count. Set `DEB_TICKS` between 2 and 10 to get a 2 to 10 ms filter.

Top module: `altmode_lane_ctrl`

## Requirements
- R1: mode_p0=1, mode_p1=0 (USB only): usb_path_en=1, both DisplayPort pair enables 0, all four AUX closures 0, shutdown=0.
- R2: mode_p0=1, mode_p1=1 (USB plus two lanes): usb_path_en=1, dp_pair1_en=0, the AUX switch closed, dp_pair0_en subject to R5 and R8.
- R3: mode_p0=0, mode_p1=1 (four lanes): usb_path_en=0, the AUX switch closed, both pair enables subject to R5 and R8.
- R4: mode_p0=0, mode_p1=0 and the reset state: shutdown=1, every enable and every AUX closure 0.
- R5: while the filtered hot-plug level is low, both DisplayPort pair enables are 0, and the AUX switch remains closed if mode_p1 is high.
- R6: a falling mode_p1 or hot_plug is seen only after DEB_TICKS tick pulses with the input continuously low. A return high restarts the count. A rise reaches the outputs without waiting for a tick.
- R7: when the AUX switch is closed, orient=0 closes auxp_sbu1 and auxn_sbu2, and orient=1 closes auxp_sbu2 and auxn_sbu1. lane_swap always follows orient.
- R8: with snoop_off=1 every lane pair allowed by the mode is enabled. With snoop_off=0, link_width 00 enables no pair, 01 enables pair 0 only, and 1x enables both pairs (within the mode).
- R9: moving between USB-only and four-lane mode through the state with both mode pins high keeps usb_path_en and dp_pair0_en free of drops during the overlap.
- R10: after a pin change that needs no debounce, the outputs settle within 4 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | One-cycle 1 kHz debounce tick enable |
| mode_p0 | input | 1 | USB-path mode pin |
| mode_p1 | input | 1 | DisplayPort mode pin (fall debounced) |
| orient | input | 1 | Connector orientation |
| hot_plug | input | 1 | Sink hot-plug level (fall debounced) |
| snoop_off | input | 1 | 1 = ignore snooped width, open all mode lanes |
| link_width | input | 2 | Snooped trained width: 00 none, 01 up to two lanes, 1x four lanes |
| usb_path_en | output | 1 | USB path enable |
| dp_pair0_en | output | 1 | DisplayPort lanes 0-1 enable |
| dp_pair1_en | output | 1 | DisplayPort lanes 2-3 enable |
| lane_swap | output | 1 | Lane steering select |
| auxp_sbu1 | output | 1 | Close AUX+ to SBU1 |
| auxp_sbu2 | output | 1 | Close AUX+ to SBU2 |
| auxn_sbu1 | output | 1 | Close AUX- to SBU1 |
| auxn_sbu2 | output | 1 | Close AUX- to SBU2 |
| shutdown | output | 1 | Shutdown flag |

## Verification
A stuck or miscounted debounce counter shows at the ports as a pair enable or AUX closure that drops one tick early or late. The bench counts ticks exactly, so this is caught on the pulse where the change should happen. A wrong mode or snoop decode shows as a wrong output vector about four cycles after the pin change. The exhaustive pin sweep exposes every such corner. A swapped AUX crossover shows as soon as the switch closes with orient high.

// File: rtl/altmode_pkg.sv
package altmode_pkg;
    typedef struct packed {
        logic usb_en;
        logic dp0_en;
        logic dp1_en;
        logic swap;
        logic p_sbu1;
        logic p_sbu2;
        logic n_sbu1;
        logic n_sbu2;
        logic sd;
    } ctl_out_t;

    localparam ctl_out_t CTL_RESET = '{usb_en: 1'b0, dp0_en: 1'b0, dp1_en: 1'b0,
                                       swap: 1'b0, p_sbu1: 1'b0, p_sbu2: 1'b0,
                                       n_sbu1: 1'b0, n_sbu2: 1'b0, sd: 1'b1};
endpackage

// File: rtl/alt_sync.sv
module alt_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign q[i] = st_q.s2[i];
    end
endmodule

// File: rtl/alt_fall_filter.sv
module alt_fall_filter #(
    parameter int DEB_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sig,
    output logic filt
);
    localparam int CW = $clog2(DEB_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sig) begin
            st_d.lvl = 1'b1;
            st_d.cnt = '0;
        end else if (!st_q.lvl) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt == LAST) begin
                st_d.lvl = 1'b0;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign filt = st_q.lvl;

    // R6: rising input passes without waiting for a tick
    a_r6_rise_fast: assert property (@(posedge clk) disable iff (!rst_n)
        sig |=> st_q.lvl);
    // R6: a fall of the filtered level needs a tick while the input is low
    a_r6_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.lvl) |-> $past(tick && !sig));
    // R6: counter never passes its threshold
    a_r6_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);
endmodule

// File: rtl/altmode_lane_ctrl.sv
module altmode_lane_ctrl
    import altmode_pkg::*;
#(
    parameter int DEB_TICKS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1ms,
    input  logic       mode_p0,
    input  logic       mode_p1,
    input  logic       orient,
    input  logic       hot_plug,
    input  logic       snoop_off,
    input  logic [1:0] link_width,
    output logic       usb_path_en,
    output logic       dp_pair0_en,
    output logic       dp_pair1_en,
    output logic       lane_swap,
    output logic       auxp_sbu1,
    output logic       auxp_sbu2,
    output logic       auxn_sbu1,
    output logic       auxn_sbu2,
    output logic       shutdown
);
    localparam int NSYNC = 7;
    localparam int NFILT = 2;

    logic [NSYNC-1:0] raw_s;
    logic [NSYNC-1:0] syn_s;
    logic [NFILT-1:0] flt_in;
    logic [NFILT-1:0] flt_out;

    assign raw_s = {link_width, snoop_off, hot_plug, orient, mode_p1, mode_p0};

    alt_sync #(.W(NSYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_s), .q(syn_s)
    );

    logic       m0_s, fl_s, sdis_s;
    logic [1:0] wid_s;
    assign m0_s   = syn_s[0];
    assign fl_s   = syn_s[2];
    assign sdis_s = syn_s[4];
    assign wid_s  = syn_s[6:5];
    assign flt_in = {syn_s[3], syn_s[1]};

    for (genvar i = 0; i < NFILT; i++) begin : g_flt
        alt_fall_filter #(.DEB_TICKS(DEB_TICKS)) u_flt (
            .clk(clk), .rst_n(rst_n), .tick(tick_1ms),
            .sig(flt_in[i]), .filt(flt_out[i])
        );
    end

    logic m1_f, hp_f;
    assign m1_f = flt_out[0];
    assign hp_f = flt_out[1];

    ctl_out_t out_d, out_q;
    logic     allow0, allow1, aux_on;

    always_comb begin
        allow0 = sdis_s || (wid_s != 2'b00);
        allow1 = sdis_s || wid_s[1];
        aux_on = m1_f;
        out_d.usb_en = m0_s;
        out_d.dp0_en = m1_f && hp_f && allow0;
        out_d.dp1_en = m1_f && !m0_s && hp_f && allow1;
        out_d.swap   = fl_s;
        out_d.p_sbu1 = aux_on && !fl_s;
        out_d.n_sbu2 = aux_on && !fl_s;
        out_d.p_sbu2 = aux_on && fl_s;
        out_d.n_sbu1 = aux_on && fl_s;
        out_d.sd     = !m0_s && !m1_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= CTL_RESET;
        else        out_q <= out_d;
    end

    assign usb_path_en = out_q.usb_en;
    assign dp_pair0_en = out_q.dp0_en;
    assign dp_pair1_en = out_q.dp1_en;
    assign lane_swap   = out_q.swap;
    assign auxp_sbu1   = out_q.p_sbu1;
    assign auxp_sbu2   = out_q.p_sbu2;
    assign auxn_sbu1   = out_q.n_sbu1;
    assign auxn_sbu2   = out_q.n_sbu2;
    assign shutdown    = out_q.sd;

    // R4: shutdown keeps every path and switch open
    a_r4_shutdown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.sd |-> !(out_q.usb_en || out_q.dp0_en || out_q.dp1_en ||
                       out_q.p_sbu1 || out_q.p_sbu2 || out_q.n_sbu1 || out_q.n_sbu2));
    // R3: upper lane pair never shares the connector with USB
    a_r3_four_lane_no_usb: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.dp1_en |-> (!out_q.usb_en && out_q.dp0_en));
    // R5: any active lane implies a closed AUX switch
    a_r5_lanes_need_aux: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.dp0_en || out_q.dp1_en) |-> (out_q.p_sbu1 || out_q.p_sbu2));
    // R7: crossover follows orientation, one SBU per AUX wire
    a_r7_cross: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.p_sbu1 || out_q.p_sbu2) |->
            (out_q.p_sbu2 == out_q.swap && out_q.n_sbu1 == out_q.p_sbu2 &&
             out_q.n_sbu2 == out_q.p_sbu1 && out_q.p_sbu1 != out_q.p_sbu2));
    // R9: pair 0 drops only for a cause seen the cycle before
    a_r9_dp0_no_glitch: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_q.dp0_en) |-> $past(!m1_f || !hp_f || !(sdis_s || wid_s != 2'b00)));
    // R9: USB path drops only when its pin went low
    a_r9_usb_no_glitch: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_q.usb_en) |-> $past(!m0_s));
endmodule

// File: tb/tb_altmode_lane_ctrl.sv
`timescale 1ns/1ps
module tb_altmode_lane_ctrl;
    localparam int DEB = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_1ms = 1'b0;
    logic mode_p0 = 1'b0, mode_p1 = 1'b0, orient = 1'b0, hot_plug = 1'b0, snoop_off = 1'b0;
    logic [1:0] link_width = 2'b00;
    logic usb_path_en, dp_pair0_en, dp_pair1_en, lane_swap;
    logic auxp_sbu1, auxp_sbu2, auxn_sbu1, auxn_sbu2, shutdown;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    altmode_lane_ctrl #(.DEB_TICKS(DEB)) dut (
        .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms),
        .mode_p0(mode_p0), .mode_p1(mode_p1), .orient(orient),
        .hot_plug(hot_plug), .snoop_off(snoop_off), .link_width(link_width),
        .usb_path_en(usb_path_en), .dp_pair0_en(dp_pair0_en), .dp_pair1_en(dp_pair1_en),
        .lane_swap(lane_swap), .auxp_sbu1(auxp_sbu1), .auxp_sbu2(auxp_sbu2),
        .auxn_sbu1(auxn_sbu1), .auxn_sbu2(auxn_sbu2), .shutdown(shutdown)
    );

    function automatic logic [8:0] got();
        return {usb_path_en, dp_pair0_en, dp_pair1_en, lane_swap,
                auxp_sbu1, auxp_sbu2, auxn_sbu1, auxn_sbu2, shutdown};
    endfunction

    // expected vector from the requirements; f1/h are the filtered levels
    function automatic logic [8:0] model(logic c0, logic f1, logic fl, logic h,
                                         logic sdis, logic [1:0] w);
        logic a0, a1;
        a0 = sdis | (w != 2'b00);
        a1 = sdis | w[1];
        return {c0, f1 & h & a0, f1 & ~c0 & h & a1, fl,
                f1 & ~fl, f1 & fl, f1 & fl, f1 & ~fl, ~c0 & ~f1};
    endfunction

    task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tick();
        @(negedge clk) tick_1ms = 1'b1;
        @(negedge clk) tick_1ms = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // R4: reset state
        mode_p0 = 1; mode_p1 = 1; hot_plug = 1; snoop_off = 1;
        cyc(3);
        chk("R4 reset", got(), 9'b000000001);
        rst_n = 1'b1;
        cyc(4);
        // R10: within 4 cycles of release the configured mode shows
        chk("R10 settle", got(), model(1, 1, 0, 1, 1, 2'b00));

        // R1 R2 R3 R4 R5 R7 R8: exhaustive sweep from reset
        for (int v = 0; v < 128; v++) begin
            do_reset();
            mode_p0 = v[0]; mode_p1 = v[1]; orient = v[2]; hot_plug = v[3];
            snoop_off = v[4]; link_width = v[6:5];
            cyc(5);
            chk("R1 R2 R3 R4 R5 R7 R8 sweep", got(),
                model(v[0], v[1], v[2], v[3], v[4], v[6:5]));
        end

        // R6 R5: hot-plug fall debounce in four-lane mode, flipped
        do_reset();
        mode_p0 = 0; mode_p1 = 1; orient = 1; hot_plug = 1; snoop_off = 1; link_width = 0;
        cyc(5);
        hot_plug = 0;
        cyc(4);
        for (int t = 0; t < DEB - 1; t++) pulse_tick();
        cyc(3);
        chk("R6 hpd held before last tick", got(), model(0, 1, 1, 1, 1, 0));
        hot_plug = 1;           // return high restarts count
        cyc(4);
        hot_plug = 0;
        cyc(4);
        for (int t = 0; t < DEB - 1; t++) pulse_tick();
        cyc(3);
        chk("R6 hpd restart", got(), model(0, 1, 1, 1, 1, 0));
        pulse_tick();
        cyc(3);
        chk("R5 hpd lost aux closed", got(), model(0, 1, 1, 0, 1, 0));
        hot_plug = 1;
        cyc(4);
        chk("R6 hpd rise immediate", got(), model(0, 1, 1, 1, 1, 0));

        // R6: mode_p1 fall debounce, USB+2DP to USB-only
        mode_p0 = 1; orient = 0;
        cyc(5);
        mode_p1 = 0;
        cyc(4);
        for (int t = 0; t < DEB - 1; t++) pulse_tick();
        cyc(3);
        chk("R6 ctl fall held", got(), model(1, 1, 0, 1, 1, 0));
        pulse_tick();
        cyc(3);
        chk("R6 ctl fall taken", got(), model(1, 0, 0, 1, 1, 0));

        // R9: USB-only -> overlap -> four-lane without drops
        mode_p1 = 1;
        cyc(5);
        chk("R9 overlap", got(), model(1, 1, 0, 1, 1, 0));
        mode_p0 = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (!dp_pair0_en) begin
                n_err++;
                $display("FAIL R9: dp_pair0_en got 0 expected 1");
            end
        end
        n_chk++;
        chk("R9 four-lane", got(), model(0, 1, 0, 1, 1, 0));
        // back: four-lane -> overlap -> USB-only
        mode_p0 = 1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (!dp_pair0_en) begin
                n_err++;
                $display("FAIL R9: dp_pair0_en back got 0 expected 1");
            end
        end
        n_chk++;
        mode_p1 = 0;
        cyc(4);
        for (int t = 0; t < DEB; t++) pulse_tick();
        cyc(3);
        chk("R9 R1 back to usb", got(), model(1, 0, 0, 1, 1, 0));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule